// File: doc/BRIEF.md
# DRAM Error Address Bank and Pseudochannel De-hasher

This block accepts a 28-bit DRAM error address as it is reported for a memory fault. It splits the address into column, bank, row, pseudochannel and stack-ID fields. It then removes the XOR hashing that the memory controller applied to the bank bits and to the pseudochannel bit. Column, row and stack ID pass through unchanged. The bank and pseudochannel values come out corrected, so that later logic can rebuild the address the fault really belongs to.

The hash masks live in six 32-bit configuration words. Initialisation code loads them through a plain address/data/write-enable port. After reset every word is zero, so no hashing is undone until software enables it. Addresses enter on a valid/ready handshake. The result sits in a single output register and is offered on a valid/ready handshake one cycle after the address is accepted.

Top module: `dram_dehash`

## Requirements
- R1: The input address is split as column = in_addr[5:1], bank = in_addr[9:6], row = in_addr[24:10], pseudochannel = in_addr[25] and stack ID = in_addr[27:26]; in_addr[0] is ignored. Column, row and stack ID reach out_col, out_row and out_sid unchanged.
- R2: Config word k, for k in 0..3, controls bank bit k. The word has an enable at bit 0. Its column mask is at bits 13:1, where word bit 1+j covers column bit j. Its row mask is at bits 31:14, where word bit 14+j covers row bit j. When the enable is 1, out_bank[k] = bank[k] XOR parity(column AND column mask) XOR parity(row AND row mask).
- R3: While bit 0 of a hash word is 0, the bit it controls passes through unchanged, whatever masks the word holds.
- R4: Column mask bits for column positions 5..12 (word bits 6..13) and row mask bits for row positions 15..17 (word bits 29..31) have no effect on the result.
- R5: Config word 4 has the same layout as the bank words and controls the pseudochannel. Config word 5 holds a 6-bit mask in bits 5:0. When word 4 is enabled, out_pc = pc XOR parity(masked column) XOR parity(masked row) XOR parity({sid, bank} AND word5[5:0]). In the vector {sid, bank}, the stack ID sits in bits 5:4.
- R6: The bank vector that feeds the pseudochannel term of R5 is the corrected bank, after the R2 flips have been applied.
- R7: All config words reset to zero, so all outputs pass through unchanged. A write with cfg_we = 1 to word address 6 or 7 changes nothing.
- R8: in_ready equals (not out_valid) or out_ready. An address accepted at a clock edge shows up at the next edge with out_valid = 1, and its result uses the configuration held at the moment of acceptance.
- R9: While out_valid = 1 and out_ready = 0, out_valid and all output fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config word write strobe |
| cfg_addr | input | 3 | Config word index (0-3 bank, 4 pseudochannel, 5 bank XOR mask) |
| cfg_wdata | input | 32 | Config write data |
| in_valid | input | 1 | Error address is valid |
| in_ready | output | 1 | Block can take an address |
| in_addr | input | 28 | Reported DRAM error address |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_col | output | 5 | Column field |
| out_bank | output | 4 | De-hashed bank |
| out_row | output | 15 | Row field |
| out_pc | output | 1 | De-hashed pseudochannel |
| out_sid | output | 2 | Stack ID field |

## Verification
The handshake properties assume that the source holds in_addr and in_valid steady until the address is accepted. The stimulus keeps to this because one driver task asserts in_valid and releases it only after seeing in_ready at an edge. They also assume that configuration writes do not race with the value being checked. The bench therefore writes config words only after every expected result has been drained, while out_ready is throttled pseudo-randomly or held low on purpose to create back-pressure.

// File: rtl/dehash_pkg.sv
package dehash_pkg;
   // default field widths of the reported error address
   localparam int DEF_COL_W      = 5;
   localparam int DEF_BANK_W     = 4;
   localparam int DEF_ROW_W      = 15;
   localparam int DEF_SID_W      = 2;
   // config word geometry
   localparam int DEF_CFG_DW     = 32;
   localparam int DEF_CFG_AW     = 3;
   localparam int DEF_COL_MASK_W = 13;
   localparam int DEF_ROW_MASK_W = 18;

   // role of a config word index, derived from the bank count
   typedef enum logic [1:0] {
      WORD_BANK,
      WORD_PC,
      WORD_PCX,
      WORD_NONE
   } word_role_e;

   function automatic word_role_e role_of(input int idx, input int bank_w);
      if (idx < bank_w)       return WORD_BANK;
      if (idx == bank_w)      return WORD_PC;
      if (idx == bank_w + 1)  return WORD_PCX;
      return WORD_NONE;
   endfunction
endpackage

// File: rtl/dehash_cfg_regs.sv
module dehash_cfg_regs
   import dehash_pkg::*;
#(
   parameter int BANK_W = DEF_BANK_W,
   parameter int SID_W  = DEF_SID_W,
   parameter int CFG_AW = DEF_CFG_AW,
   parameter int CFG_DW = DEF_CFG_DW
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [CFG_AW-1:0]              addr,
   input  logic [CFG_DW-1:0]              wdata,
   output logic [BANK_W-1:0][CFG_DW-1:0]  bank_words,
   output logic [CFG_DW-1:0]              pc_word,
   output logic [BANK_W+SID_W-1:0]        pcx_mask
);
   localparam int PCX_W   = BANK_W + SID_W;
   localparam int N_WORDS = BANK_W + 2;

   if ((1 << CFG_AW) < N_WORDS) begin : g_bad_aw
      $error("dehash_cfg_regs: CFG_AW too small for %0d words", N_WORDS);
   end
   if (PCX_W > CFG_DW) begin : g_bad_pcx
      $error("dehash_cfg_regs: bank XOR mask wider than a config word");
   end

   for (genvar g = 0; g < BANK_W; g++) begin : g_bank
      logic [CFG_DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (we && (addr == CFG_AW'(g)))
            word_q <= wdata;
      end
      assign bank_words[g] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_word <= '0;
      else if (we && (addr == CFG_AW'(BANK_W)))
         pc_word <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcx_mask <= '0;
      else if (we && (addr == CFG_AW'(BANK_W + 1)))
         pcx_mask <= wdata[PCX_W-1:0];
   end
endmodule

// File: rtl/dehash_parity_term.sv
module dehash_parity_term
   import dehash_pkg::*;
#(
   parameter int COL_W      = DEF_COL_W,
   parameter int ROW_W      = DEF_ROW_W,
   parameter int COL_MASK_W = DEF_COL_MASK_W,
   parameter int ROW_MASK_W = DEF_ROW_MASK_W,
   parameter int CFG_DW     = DEF_CFG_DW
) (
   input  logic [COL_W-1:0]  col,
   input  logic [ROW_W-1:0]  row,
   input  logic [CFG_DW-1:0] word,
   output logic              flip
);
   localparam int CM_LO = 1;
   localparam int RM_LO = CM_LO + COL_MASK_W;

   if (1 + COL_MASK_W + ROW_MASK_W != CFG_DW) begin : g_bad_layout
      $error("dehash_parity_term: enable+masks must fill the word");
   end
   if (COL_MASK_W < COL_W || ROW_MASK_W < ROW_W) begin : g_bad_mask
      $error("dehash_parity_term: mask narrower than its field");
   end

   logic                  en;
   logic [COL_MASK_W-1:0] col_mask, col_ext;
   logic [ROW_MASK_W-1:0] row_mask, row_ext;

   assign en       = word[0];
   assign col_mask = word[CM_LO +: COL_MASK_W];
   assign row_mask = word[RM_LO +: ROW_MASK_W];
   // zero-extended fields: mask bits past the field width meet zeros
   assign col_ext  = COL_MASK_W'(col);
   assign row_ext  = ROW_MASK_W'(row);

   assign flip = en & ((^(col_ext & col_mask)) ^ (^(row_ext & row_mask)));
endmodule

// File: rtl/dram_dehash.sv
module dram_dehash
   import dehash_pkg::*;
#(
   parameter int COL_W      = DEF_COL_W,
   parameter int BANK_W     = DEF_BANK_W,
   parameter int ROW_W      = DEF_ROW_W,
   parameter int SID_W      = DEF_SID_W,
   parameter int CFG_AW     = DEF_CFG_AW,
   parameter int CFG_DW     = DEF_CFG_DW,
   parameter int COL_MASK_W = DEF_COL_MASK_W,
   parameter int ROW_MASK_W = DEF_ROW_MASK_W,
   parameter int ADDR_W     = 1 + COL_W + BANK_W + ROW_W + 1 + SID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [COL_W-1:0]  out_col,
   output logic [BANK_W-1:0] out_bank,
   output logic [ROW_W-1:0]  out_row,
   output logic              out_pc,
   output logic [SID_W-1:0]  out_sid
);
   localparam int COL_LO  = 1;
   localparam int BANK_LO = COL_LO + COL_W;
   localparam int ROW_LO  = BANK_LO + BANK_W;
   localparam int PC_BIT  = ROW_LO + ROW_W;
   localparam int SID_LO  = PC_BIT + 1;
   localparam int PCX_W   = BANK_W + SID_W;

   if (SID_LO + SID_W != ADDR_W) begin : g_bad_addr
      $error("dram_dehash: ADDR_W does not match the field widths");
   end
   if (role_of(BANK_W + 2, BANK_W) != WORD_NONE) begin : g_bad_role
      $error("dram_dehash: word role decode inconsistent");
   end

   // ---------------- configuration ----------------
   logic [BANK_W-1:0][CFG_DW-1:0] bank_words;
   logic [CFG_DW-1:0]             pc_word;
   logic [PCX_W-1:0]              pcx_mask;

   dehash_cfg_regs #(
      .BANK_W (BANK_W),
      .SID_W  (SID_W),
      .CFG_AW (CFG_AW),
      .CFG_DW (CFG_DW)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .addr       (cfg_addr),
      .wdata      (cfg_wdata),
      .bank_words (bank_words),
      .pc_word    (pc_word),
      .pcx_mask   (pcx_mask)
   );

   // ---------------- field split ----------------
   logic [COL_W-1:0]  col_raw;
   logic [BANK_W-1:0] bank_raw;
   logic [ROW_W-1:0]  row_raw;
   logic              pc_raw;
   logic [SID_W-1:0]  sid_raw;
   logic              unused_zero_lsb;

   assign col_raw         = in_addr[COL_LO  +: COL_W];
   assign bank_raw        = in_addr[BANK_LO +: BANK_W];
   assign row_raw         = in_addr[ROW_LO  +: ROW_W];
   assign pc_raw          = in_addr[PC_BIT];
   assign sid_raw         = in_addr[SID_LO  +: SID_W];
   assign unused_zero_lsb = in_addr[0];

   // ---------------- bank de-hash ----------------
   logic [BANK_W-1:0] bank_flip;
   logic [BANK_W-1:0] bank_fix;

   for (genvar b = 0; b < BANK_W; b++) begin : g_bank_hash
      dehash_parity_term #(
         .COL_W      (COL_W),
         .ROW_W      (ROW_W),
         .COL_MASK_W (COL_MASK_W),
         .ROW_MASK_W (ROW_MASK_W),
         .CFG_DW     (CFG_DW)
      ) u_term (
         .col  (col_raw),
         .row  (row_raw),
         .word (bank_words[b]),
         .flip (bank_flip[b])
      );
   end

   assign bank_fix = bank_raw ^ bank_flip;

   // ---------------- pseudochannel de-hash (uses corrected bank) ----------------
   logic             pc_cr_flip;
   logic [PCX_W-1:0] pc_vec;
   logic             pc_bx_flip;
   logic             pc_fix;

   dehash_parity_term #(
      .COL_W      (COL_W),
      .ROW_W      (ROW_W),
      .COL_MASK_W (COL_MASK_W),
      .ROW_MASK_W (ROW_MASK_W),
      .CFG_DW     (CFG_DW)
   ) u_pc_term (
      .col  (col_raw),
      .row  (row_raw),
      .word (pc_word),
      .flip (pc_cr_flip)
   );

   assign pc_vec     = {sid_raw, bank_fix};
   assign pc_bx_flip = pc_word[0] & (^(pc_vec & pcx_mask));
   assign pc_fix     = pc_raw ^ pc_cr_flip ^ pc_bx_flip;

   // ---------------- output stage ----------------
   logic accept;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (accept) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_col  <= '0;
         out_bank <= '0;
         out_row  <= '0;
         out_pc   <= 1'b0;
         out_sid  <= '0;
      end else if (accept) begin
         out_col  <= col_raw;
         out_bank <= bank_fix;
         out_row  <= row_raw;
         out_pc   <= pc_fix;
         out_sid  <= sid_raw;
      end
   end
endmodule

// File: rtl/dram_dehash_chk.sv
module dram_dehash_chk #(
   parameter int COL_W  = 5,
   parameter int BANK_W = 4,
   parameter int ROW_W  = 15,
   parameter int SID_W  = 2,
   parameter int ADDR_W = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [COL_W-1:0]  out_col,
   input logic [BANK_W-1:0] out_bank,
   input logic [ROW_W-1:0]  out_row,
   input logic              out_pc,
   input logic [SID_W-1:0]  out_sid
);
   localparam int ROW_LO = 1 + COL_W + BANK_W;
   localparam int SID_LO = ROW_LO + ROW_W + 1;

   logic unused_chk_lsb;
   assign unused_chk_lsb = in_addr[0];

   // R8
   take_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R8
   ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R8
   valid_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   // R9
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_bank)
                                     && $stable(out_row) && $stable(out_pc) && $stable(out_sid)));

   // R1
   fields_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_col == $past(in_addr[1 +: COL_W])
                                  && out_row == $past(in_addr[ROW_LO +: ROW_W])
                                  && out_sid == $past(in_addr[SID_LO +: SID_W])));
endmodule

bind dram_dehash dram_dehash_chk #(
   .COL_W  (COL_W),
   .BANK_W (BANK_W),
   .ROW_W  (ROW_W),
   .SID_W  (SID_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_addr   (in_addr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_col   (out_col),
   .out_bank  (out_bank),
   .out_row   (out_row),
   .out_pc    (out_pc),
   .out_sid   (out_sid)
);

// File: tb/dram_dehash_test.sv
`timescale 1ns/1ps
module dram_dehash_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [27:0] in_addr = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [4:0]  out_col;
   logic [3:0]  out_bank;
   logic [14:0] out_row;
   logic        out_pc;
   logic [1:0]  out_sid;

   always #10 clk = ~clk;   // 50 MHz

   dram_dehash uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col), .out_bank(out_bank),
      .out_row(out_row), .out_pc(out_pc), .out_sid(out_sid)
   );

   int checks = 0;
   int errors = 0;
   int stall_mode = 0;   // 0 always ready, 1 throttled, 2 held low
   bit done = 1'b0;

   logic [31:0] m_bank [4];
   logic [31:0] m_pc;
   logic [5:0]  m_pcx;

   logic [26:0] exp_q [$];   // {sid, pc, row, bank, col}
   string       tag_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [26:0] model(input logic [27:0] a);
      logic [4:0]  c;
      logic [3:0]  b;
      logic [14:0] r;
      logic        p;
      logic [1:0]  s;
      c = a[5:1]; b = a[9:6]; r = a[24:10]; p = a[25]; s = a[27:26];
      for (int i = 0; i < 4; i++)
         if (m_bank[i][0])
            b[i] = b[i] ^ (^(c & m_bank[i][5:1])) ^ (^(r & m_bank[i][28:14]));
      if (m_pc[0])
         p = p ^ (^(c & m_pc[5:1])) ^ (^(r & m_pc[28:14])) ^ (^({s, b} & m_pcx));
      return {s, p, r, b, c};
   endfunction

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 3'd4)       m_bank[a] = d;
      else if (a == 3'd4) m_pc = d;
      else if (a == 3'd5) m_pcx = d[5:0];
   endtask

   task automatic send(input logic [27:0] a, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(model(a));
      tag_q.push_back(tag);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_cfg();
      for (int k = 0; k < 6; k++) cfg_write(3'(k), 32'h0);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         case (stall_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 4) != 0;
            default: out_ready = 1'b0;
         endcase
         #2;
         if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected result", 32'd1, 32'd0);
            end else begin
               logic [26:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_col == e[4:0], "R1", {t, " col"}, 32'(out_col), 32'(e[4:0]));
               check(out_row == e[23:9], "R1", {t, " row"}, 32'(out_row), 32'(e[23:9]));
               check(out_sid == e[26:25], "R1", {t, " sid"}, 32'(out_sid), 32'(e[26:25]));
               check(out_bank == e[8:5], t, "bank", 32'(out_bank), 32'(e[8:5]));
               check(out_pc == e[24], t, "pc", 32'(out_pc), 32'(e[24]));
            end
         end
      end
   end

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [4:0]  hc;
      logic [3:0]  hb;
      logic [14:0] hr;
      logic        hp;
      logic [1:0]  hs;
      for (int k = 0; k < 4; k++) m_bank[k] = '0;
      m_pc = '0; m_pcx = '0;
      repeat (3) @(negedge clk);
      #2;
      // R7 / R8 reset state
      check(out_valid == 1'b0, "R7", "reset out_valid", 32'(out_valid), 32'd0);
      check(in_ready == 1'b1, "R8", "reset in_ready", 32'(in_ready), 32'd1);
      rst_n = 1'b1;

      // R7: zero config is pass-through
      send(28'hFFF_FFFF, "R7");
      send(28'hA5A_5A5E, "R7");
      send(28'h5A5_A5A0, "R7");
      drain();

      // R8: result one cycle after acceptance
      send(28'h123_4566, "R8");
      @(negedge clk); #3;
      check(out_valid == 1'b1, "R8", "valid one cycle after take", 32'(out_valid), 32'd1);
      drain();

      // R2: bank0 by column bit0, bank2 by row bit3
      cfg_write(3'd0, 32'h0000_0003);
      cfg_write(3'd2, (32'h1 << 17) | 32'h1);
      send(28'h000_0002, "R2");
      send(28'h000_0000, "R2");
      send(28'h000_2000, "R2");
      send(28'h000_2042, "R2");
      drain();

      // R3: masks present but enable low
      clear_cfg();
      cfg_write(3'd1, 32'hFFFF_FFFE);
      cfg_write(3'd4, 32'hFFFF_FFFE);
      cfg_write(3'd5, 32'h0000_003F);
      send(28'hFFF_FFFE, "R3");
      send(28'h2AA_AAAA, "R3");
      drain();

      // R4: only out-of-range mask bits set
      clear_cfg();
      cfg_write(3'd3, 32'hE000_3FC1);
      cfg_write(3'd4, 32'hE000_3FC1);
      send(28'hFFF_FFFE, "R4");
      send(28'h3C0_03FE, "R4");
      drain();

      // R5: pseudochannel by column bit2, row bit0 and stack ID bits
      clear_cfg();
      cfg_write(3'd4, (32'h1 << 3) | (32'h1 << 14) | 32'h1);
      cfg_write(3'd5, 32'h0000_0030);
      send(28'h400_0000, "R5");
      send(28'hC00_0000, "R5");
      send(28'h000_0408, "R5");
      send(28'h200_0008, "R5");
      drain();

      // R6: pc depends on corrected bank bit0
      clear_cfg();
      cfg_write(3'd0, 32'h0000_0003);
      cfg_write(3'd4, 32'h0000_0001);
      cfg_write(3'd5, 32'h0000_0001);
      send(28'h000_0002, "R6");   // raw bank0=0, corrected 1, pc flips to 1
      send(28'h000_0040, "R6");   // raw bank0=1, col0=0, pc flips to 1
      send(28'h000_0042, "R6");   // raw bank0=1, corrected 0, pc stays 0
      drain();

      // R7: writes to unused indexes are ignored
      clear_cfg();
      cfg_write(3'd6, 32'hFFFF_FFFF);
      cfg_write(3'd7, 32'hFFFF_FFFF);
      send(28'hFFF_FFFE, "R7");
      send(28'h6B5_3C2A, "R7");
      drain();

      // R9: held output under back-pressure
      stall_mode = 2;
      send(28'h9C3_A5F2, "R9");
      repeat (2) @(negedge clk);
      #3;
      hc = out_col; hb = out_bank; hr = out_row; hp = out_pc; hs = out_sid;
      repeat (3) @(negedge clk);
      #3;
      check(out_valid == 1'b1, "R9", "valid held", 32'(out_valid), 32'd1);
      check({out_sid, out_pc, out_row, out_bank, out_col} == {hs, hp, hr, hb, hc},
            "R9", "fields held", 32'({out_sid, out_pc, out_row, out_bank, out_col}),
            32'({hs, hp, hr, hb, hc}));
      check(in_ready == 1'b0, "R8", "ready low while full and stalled", 32'(in_ready), 32'd0);
      stall_mode = 0;
      drain();

      // R2 / R5: random configs and addresses with throttled consumer
      for (int ph = 0; ph < 6; ph++) begin
         stall_mode = 0;
         for (int k = 0; k < 6; k++) cfg_write(3'(k), $urandom);
         stall_mode = 1;
         for (int n = 0; n < 40; n++) send(28'($urandom) & 28'hFFF_FFFE, (n % 2) ? "R2" : "R5");
         drain();
      end
      stall_mode = 0;
      drain();

      done = 1'b1;
      finish_run();
   end
endmodule